// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block turns a set of pending interrupt sources into a single priority level and decides whether the core should take an interrupt trap. It looks at two kinds of source: software request bits and external interrupt lines. Each kind has its own bit window and its own rule for mapping a bit to a level in a shared priority space. The block compares the winning level with the current processor priority. If the winner is strictly higher, it issues a one-cycle trap request. On the same edge it loads two status registers: a bitmask of every source that contributed, and the identifier of the winning level.

An evaluation happens only when the core has flagged that interrupts need checking. That flag is set by `check_req` and is consumed by the evaluation. Evaluation is held off while the core executes privileged firmware, while a fault is pending, or while an instruction-fetch miss is completing. During that time the flag is kept for later. If an asynchronous-trap request is non-zero during an evaluation, the block reports it as an unsupported condition.

Top module: `irq_level_resolver`

## Requirements
- R1: A software request bit at index i, with SW_LO <= i < SW_HI (defaults 1 and 16), maps to level i - SW_LO + 1. With the defaults, software bit 5 gives level 5.
- R2: An external line at index i, with EXT_LO <= i < EXT_HI (defaults 16 and 31), maps to level i.
- R3: When several sources are active, the source with the highest index wins. Any active external line wins over every software bit.
- R4: The summary mask has bit i set for every software bit i and every external line i that is active inside its window. Bits outside both windows (with the defaults: software bit 0, software bits 16 to 31, external bits 0 to 15 and bit 31) have no effect on the summary, on the level or on the trap.
- R5: An evaluation takes a trap only when the resolved level is non-zero and strictly greater than `cur_ipl`. `trap_pulse` is then high for exactly the one cycle after the evaluating clock edge.
- R6: `isr_q` and `intid_q` load the summary and the level on the same edge that raises `trap_pulse`, and they hold their values at every other edge.
- R7: No evaluation happens while `fw_mode`, `fault_pend` or `fetch_cpl` is high. No trap follows, and a set pending flag is kept.
- R8: `check_req` sets `pending_q` at the next edge. An evaluation clears it, unless `check_req` is high in that same cycle, in which case it stays set.
- R9: If `ast_req` is non-zero in an evaluating cycle, `async_err` is high for the one following cycle, whether or not a trap is taken.
- R10: While `rst_n` is low, all outputs are zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_req | input | 1 | Requests that interrupts be evaluated |
| sw_req | input | SUM_W | Software request bits |
| ext_irq | input | SUM_W | External interrupt lines |
| cur_ipl | input | LVL_W | Current processor priority level |
| fw_mode | input | 1 | Core is in privileged firmware mode |
| fault_pend | input | 1 | A fault is pending |
| fetch_cpl | input | 1 | Core is completing a fetch miss |
| ast_req | input | AST_W | Asynchronous-trap request (unsupported if non-zero) |
| trap_pulse | output | 1 | One-cycle interrupt trap request |
| isr_q | output | SUM_W | Interrupt summary register |
| intid_q | output | LVL_W | Winning level register |
| pending_q | output | 1 | Check-pending flag |
| async_err | output | 1 | Unsupported asynchronous-trap indication |

## Verification
The hardest case to reach is an evaluation that lands exactly when the flag is being re-armed, or exactly when a gate opens. In those cycles the flag must survive, or be consumed, in a way that depends on how three inputs line up within one cycle. Directed steps therefore hold `check_req` high across an evaluating edge, and raise a pending request under `fw_mode` before releasing the gate. A long pseudo-random phase follows. In that phase the gates and `check_req` toggle independently, so these coincidences recur many times. The phase also uses sparse source patterns that straddle the window edges and levels that tie with `cur_ipl`.

// File: rtl/irq_lvl_pkg.sv
// Package: shared types for the interrupt level resolver.
// Assumes: nothing beyond the parameters of the units that import it.
package irq_lvl_pkg;

    // How a source window maps a bit index to a priority level.
    typedef enum logic {
        MAP_OFFSET = 1'b0,  // level = index - window_low + 1
        MAP_DIRECT = 1'b1   // level = index
    } map_kind_e;

endpackage

// File: rtl/irq_range_scan.sv
// Module: irq_range_scan
// Scans one window [LO, HI) of a request vector. It masks the bits outside
// the window, reports whether any bit inside is active, and gives the level
// of the highest active bit using the mapping chosen by KIND.
// Assumes: HI <= SUM_W and every mapped level fits in LVL_W bits.
module irq_range_scan
    import irq_lvl_pkg::*;
#(
    parameter int        SUM_W = 32,
    parameter int        LVL_W = 5,
    parameter int        LO    = 1,
    parameter int        HI    = 16,
    parameter map_kind_e KIND  = MAP_OFFSET
) (
    input  logic [SUM_W-1:0] req,
    output logic             hit,
    output logic [LVL_W-1:0] lvl,
    output logic [SUM_W-1:0] mask
);

    localparam int BASE = (KIND == MAP_OFFSET) ? (LO - 1) : 0;

    // Builds the constant window mask from the bounds.
    function automatic logic [SUM_W-1:0] win_f();
        logic [SUM_W-1:0] w;
        w = '0;
        for (int k = 0; k < SUM_W; k++) begin
            w[k] = (k >= LO) && (k < HI);
        end
        return w;
    endfunction

    localparam logic [SUM_W-1:0] WIN = win_f();

    // One gate per bit: keep request bits that lie inside the window.
    for (genvar gi = 0; gi < SUM_W; gi++) begin : g_mask
        assign mask[gi] = req[gi] & WIN[gi];
    end

    assign hit = |mask;

    // Low-to-high scan so the highest active index sets the level.
    always_comb begin
        lvl = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (mask[i]) begin
                lvl = LVL_W'(i - BASE);
            end
        end
    end

endmodule

// File: rtl/irq_gate_ctl.sv
// Module: irq_gate_ctl
// Holds the check-pending flag and decides when an evaluation runs.
// An evaluation needs the flag set and all three gates low. A new request
// in the evaluating cycle keeps the flag set.
// Assumes: synchronous active-low reset.
module irq_gate_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic check_req,
    input  logic fw_mode,
    input  logic fault_pend,
    input  logic fetch_cpl,
    output logic pending_q,
    output logic eval
);

    // Evaluation window: flag armed and no gating condition active.
    assign eval = pending_q & ~fw_mode & ~fault_pend & ~fetch_cpl;

    // Pending flag: a new request sets it, an evaluation consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else begin
            pending_q <= check_req | (pending_q & ~eval);
        end
    end

endmodule

// File: rtl/irq_level_resolver.sv
// Module: irq_level_resolver (top)
// Resolves software and external interrupt sources into one level. When an
// evaluation finds that level above the current priority, it issues a
// one-cycle trap and loads the summary and level status registers on the
// same edge. It also flags an unsupported asynchronous-trap request.
// Assumes: EXT_LO > SW_HI - SW_LO, so that every external level is above
// every software level; both windows lie inside SUM_W.
module irq_level_resolver
    import irq_lvl_pkg::*;
#(
    parameter int SUM_W  = 32,
    parameter int LVL_W  = 5,
    parameter int SW_LO  = 1,
    parameter int SW_HI  = 16,
    parameter int EXT_LO = 16,
    parameter int EXT_HI = 31,
    parameter int AST_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             check_req,
    input  logic [SUM_W-1:0] sw_req,
    input  logic [SUM_W-1:0] ext_irq,
    input  logic [LVL_W-1:0] cur_ipl,
    input  logic             fw_mode,
    input  logic             fault_pend,
    input  logic             fetch_cpl,
    input  logic [AST_W-1:0] ast_req,
    output logic             trap_pulse,
    output logic [SUM_W-1:0] isr_q,
    output logic [LVL_W-1:0] intid_q,
    output logic             pending_q,
    output logic             async_err
);

    logic             eval;
    logic             sw_hit;
    logic             ext_hit;
    logic [LVL_W-1:0] sw_lvl;
    logic [LVL_W-1:0] ext_lvl;
    logic [SUM_W-1:0] sw_mask;
    logic [SUM_W-1:0] ext_mask;
    logic [LVL_W-1:0] win_lvl;
    logic [SUM_W-1:0] summary;
    logic             take;

    irq_gate_ctl u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_req  (check_req),
        .fw_mode    (fw_mode),
        .fault_pend (fault_pend),
        .fetch_cpl  (fetch_cpl),
        .pending_q  (pending_q),
        .eval       (eval)
    );

    irq_range_scan #(
        .SUM_W (SUM_W), .LVL_W (LVL_W),
        .LO    (SW_LO), .HI    (SW_HI), .KIND (MAP_OFFSET)
    ) u_sw_scan (
        .req  (sw_req),
        .hit  (sw_hit),
        .lvl  (sw_lvl),
        .mask (sw_mask)
    );

    irq_range_scan #(
        .SUM_W (SUM_W), .LVL_W (LVL_W),
        .LO    (EXT_LO), .HI   (EXT_HI), .KIND (MAP_DIRECT)
    ) u_ext_scan (
        .req  (ext_irq),
        .hit  (ext_hit),
        .lvl  (ext_lvl),
        .mask (ext_mask)
    );

    // Merge: external sources are scanned last, so any active line wins.
    always_comb begin
        win_lvl = ext_hit ? ext_lvl : (sw_hit ? sw_lvl : '0);
        summary = sw_mask | ext_mask;
        take    = eval && (win_lvl != '0) && (win_lvl > cur_ipl);
    end

    // Trap pulse and status registers, all loaded on the evaluating edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_pulse <= 1'b0;
            isr_q      <= '0;
            intid_q    <= '0;
            async_err  <= 1'b0;
        end else begin
            trap_pulse <= take;
            async_err  <= eval && (ast_req != '0);
            if (take) begin
                isr_q   <= summary;
                intid_q <= win_lvl;
            end
        end
    end

endmodule

// File: rtl/irq_level_resolver_chk.sv
// Module: irq_level_resolver_chk
// Port-level temporal checks for irq_level_resolver, attached by bind.
// Assumes: synchronous active-low reset; used only through the bind below.
module irq_level_resolver_chk #(
    parameter int SUM_W = 32,
    parameter int LVL_W = 5,
    parameter int AST_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             check_req,
    input logic [LVL_W-1:0] cur_ipl,
    input logic             fw_mode,
    input logic             fault_pend,
    input logic             fetch_cpl,
    input logic [AST_W-1:0] ast_req,
    input logic             trap_pulse,
    input logic [SUM_W-1:0] isr_q,
    input logic [LVL_W-1:0] intid_q,
    input logic             pending_q,
    input logic             async_err
);

    p_trap_above_ipl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (intid_q != '0) && (intid_q > $past(cur_ipl)));

    p_summary_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_pulse |-> (isr_q != '0));

    p_status_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_pulse |-> ($stable(intid_q) && $stable(isr_q)));

    p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_mode || fault_pend || fetch_cpl) |=> !trap_pulse);

    p_gate_keeps_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && (fw_mode || fault_pend || fetch_cpl)) |=> pending_q);

    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        check_req |=> pending_q);

    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !fw_mode && !fault_pend && !fetch_cpl && !check_req)
        |=> !pending_q);

    p_async_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        async_err |-> ($past(ast_req) != '0));

endmodule

bind irq_level_resolver irq_level_resolver_chk #(
    .SUM_W (SUM_W),
    .LVL_W (LVL_W),
    .AST_W (AST_W)
) u_chk (.*);

// File: tb/sim_irq_level_resolver.sv
`timescale 1ns/1ps
// Bench for irq_level_resolver. A behavioural model advances on every
// rising edge; the bench compares all outputs with it on every falling edge.
module sim_irq_level_resolver;

    localparam int SUM_W = 32;
    localparam int LVL_W = 5;
    localparam int AST_W = 4;
    localparam int SWL = 1, SWH = 16, EXL = 16, EXH = 31;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             check_req = 1'b0;
    logic [SUM_W-1:0] sw_req = '0;
    logic [SUM_W-1:0] ext_irq = '0;
    logic [LVL_W-1:0] cur_ipl = '0;
    logic             fw_mode = 1'b0;
    logic             fault_pend = 1'b0;
    logic             fetch_cpl = 1'b0;
    logic [AST_W-1:0] ast_req = '0;
    logic             trap_pulse;
    logic [SUM_W-1:0] isr_q;
    logic [LVL_W-1:0] intid_q;
    logic             pending_q;
    logic             async_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state.
    bit            m_trap, m_pend, m_err;
    bit [31:0]     m_isr;
    int            m_id;

    always #2 clk = ~clk;

    irq_level_resolver #(
        .SUM_W (SUM_W), .LVL_W (LVL_W), .SW_LO (SWL), .SW_HI (SWH),
        .EXT_LO (EXL), .EXT_HI (EXH), .AST_W (AST_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .check_req (check_req),
        .sw_req (sw_req), .ext_irq (ext_irq), .cur_ipl (cur_ipl),
        .fw_mode (fw_mode), .fault_pend (fault_pend), .fetch_cpl (fetch_cpl),
        .ast_req (ast_req), .trap_pulse (trap_pulse), .isr_q (isr_q),
        .intid_q (intid_q), .pending_q (pending_q), .async_err (async_err)
    );

    // Reference model: evaluate as the requirements describe.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_trap = 0; m_pend = 0; m_err = 0; m_isr = 0; m_id = 0;
        end else begin
            bit ev;
            int lv;
            bit [31:0] sm;
            ev = m_pend && !fw_mode && !fault_pend && !fetch_cpl;
            lv = 0;
            sm = 0;
            for (int i = SWL; i < SWH; i++)
                if (sw_req[i]) begin lv = i - SWL + 1; sm[i] = 1'b1; end
            for (int i = EXL; i < EXH; i++)
                if (ext_irq[i]) begin lv = i; sm[i] = 1'b1; end
            m_trap = ev && (lv != 0) && (lv > int'(cur_ipl));
            m_err  = ev && (ast_req != 0);
            if (m_trap) begin m_isr = sm; m_id = lv; end
            m_pend = check_req ? 1'b1 : (ev ? 1'b0 : m_pend);
        end
    end

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare every output with the model, away from the rising edge.
    task automatic tick();
        @(negedge clk);
        chk("R5 trap_pulse", trap_pulse, m_trap);
        chk("R4 isr_q", isr_q, m_isr);
        chk("R3 intid_q", intid_q, m_id);
        chk("R8 pending_q", pending_q, m_pend);
        chk("R9 async_err", async_err, m_err);
    endtask

    // Arm the flag for one cycle; the evaluation edge follows.
    task automatic arm();
        check_req = 1'b1;
        tick();
        check_req = 1'b0;
        tick();
    endtask

    initial begin
        tick();
        tick();
        // R10: all outputs zero under reset
        chk("R10 reset outputs", {trap_pulse, isr_q, intid_q, pending_q, async_err}, 0);
        rst_n = 1'b1;
        tick();

        // R1: software bit 5 maps to level 5
        sw_req = 32'h20;
        arm();
        chk("R1 sw level", intid_q, 5);
        chk("R5 trap on sw", trap_pulse, 1);
        tick();
        chk("R5 single pulse", trap_pulse, 0);

        // R2, R3, R4: external 20 beats software 3 and 9
        sw_req = 32'h208; ext_irq = 32'h0010_0000;
        arm();
        chk("R2 ext level", intid_q, 20);
        chk("R4 summary", isr_q, 32'h0010_0208);

        // R3: highest external wins
        sw_req = 0; ext_irq = (32'h1 << 17) | (32'h1 << 25);
        arm();
        chk("R3 highest ext", intid_q, 25);

        // R5, R6: level equal to cur_ipl gives no trap, status kept
        cur_ipl = 25; ext_irq = 32'h1 << 25;
        arm();
        chk("R5 equal level no trap", trap_pulse, 0);
        chk("R6 id held", intid_q, 25);
        chk("R6 isr held", isr_q, (32'h1 << 17) | (32'h1 << 25));
        cur_ipl = 0;

        // R4: bits outside the windows are ignored
        sw_req = 32'h0001_0001; ext_irq = 32'h8000_0008;
        arm();
        chk("R4 out-of-window no trap", trap_pulse, 0);
        chk("R4 out-of-window isr held", isr_q, (32'h1 << 17) | (32'h1 << 25));

        // R7: firmware mode holds off evaluation and keeps the flag
        sw_req = 32'h80; fw_mode = 1'b1;
        arm();
        chk("R7 gated no trap", trap_pulse, 0);
        chk("R7 flag kept", pending_q, 1);
        fw_mode = 1'b0;
        tick();
        chk("R7 trap after release", trap_pulse, 1);
        chk("R1 level 7", intid_q, 7);

        // R9: asynchronous request during evaluation
        ast_req = 4'h2;
        arm();
        chk("R9 async flagged", async_err, 1);
        ast_req = 0;

        // R8: request held across an evaluating edge keeps the flag set
        check_req = 1'b1;
        tick(); tick(); tick();
        chk("R8 flag stays with request", pending_q, 1);
        check_req = 1'b0;
        tick(); tick();
        chk("R8 flag consumed", pending_q, 0);

        // Pseudo-random phase
        for (int n = 0; n < 4000; n++) begin
            check_req  = ($urandom_range(2) == 0);
            sw_req     = $urandom & $urandom;
            ext_irq    = ($urandom_range(3) == 0) ? ($urandom & $urandom & $urandom) : 0;
            cur_ipl    = LVL_W'($urandom_range(31));
            fw_mode    = ($urandom_range(7) == 0);
            fault_pend = ($urandom_range(9) == 0);
            fetch_cpl  = ($urandom_range(9) == 0);
            ast_req    = ($urandom_range(15) == 0) ? AST_W'($urandom) : '0;
            tick();
        end

        // R10: reset mid-run clears everything
        rst_n = 1'b0;
        tick();
        chk("R10 reset again", {trap_pulse, isr_q, intid_q, pending_q, async_err}, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule